// File: doc/BRIEF.md
# Peripheral Access Protection Gate

This block sits between one upstream APB requester and sixteen downstream peripheral ports. Address decode outside the block picks the target port by driving a one-hot select vector. In the setup phase the gate checks the transfer's protection attributes against per-port permission wires. Transfers that pass are forwarded to the selected port. Transfers that fail are completed locally and never reach a peripheral.

All configuration comes in on input wires, and the block has no registers that software can program. A parameter mask can exempt chosen ports from the security check; the privilege check still applies to those ports. A single mode wire sets how a rejected transfer ends: either with an error response, or with zero read data, no error and the write dropped. Every rejection sets a latched pending flag. The flag drives the interrupt output only while the enable wire is high, and a clear wire resets it.

The control path is a three-state machine:
- ST_IDLE: no transfer is in progress.
- ST_PASS: a permitted transfer is being forwarded.
- ST_BLOCK: a refused transfer is being completed locally.

The transitions are:
- IDLE_TO_PASS: a setup phase whose verdict is allowed.
- IDLE_TO_BLOCK: a setup phase whose verdict is refused.
- PASS_DONE: the selected port reports ready in the access phase.
- BLOCK_DONE: the first access cycle of a refused transfer.
- ABORT: the upstream select drops while PASS or BLOCK is active; the machine returns to ST_IDLE.

Top module: `apb_access_gate`

## Requirements
- R1: A permitted transfer drives `dn_psel` equal to `up_psel`, in the setup phase and in the access phase. `dn_penable` follows `up_penable` in the access phase. Address, write data, strobe, protection and write flag pass through unchanged. The selected port's read data, ready and error come back on `up_prdata`, `up_pready` and `up_pslverr`.
- R2: A transfer with `up_pprot[1]`=1 is non-secure. It is refused unless `cfg_ns_ok[j]`=1 for the selected port j.
- R3: A transfer with `up_pprot[0]`=0 is unprivileged. It is refused unless `cfg_user_ok[j]`=1 for the selected port j.
- R4: For a port j whose bit is set in parameter `SEC_BYPASS`, the non-secure check of R2 is skipped. The unprivileged check of R3 still applies to that port.
- R5: A refused transfer never asserts `dn_psel` or `dn_penable`. It completes in its first access cycle with `up_pready`=1.
- R6: When `cfg_fault_mode`=1, a refused transfer completes with `up_pslverr`=1 and `up_prdata`=0.
- R7: When `cfg_fault_mode`=0, a refused transfer completes with `up_prdata`=0 and `up_pslverr`=0. A refused write reaches no port.
- R8: Completing a refused transfer sets the pending flag at that clock edge. `irq` equals the pending flag AND `irq_en`, so a flag set while `irq_en`=0 appears on `irq` once `irq_en` rises.
- R9: While `irq_clr`=1 the pending flag is 0 after each clock edge. This holds even when a refused transfer completes in the same cycle.
- R10: After reset the machine is in ST_IDLE, `dn_psel`=0, `up_pready`=0 and `irq`=0.
- R11: The machine moves from ST_IDLE to ST_PASS or ST_BLOCK at the setup edge. It stays in ST_PASS while the port holds ready low, and returns to ST_IDLE at the completing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_psel | input | NPORTS | One-hot port select from external decode |
| up_penable | input | 1 | Upstream access phase |
| up_pwrite | input | 1 | Upstream write flag |
| up_paddr | input | AW | Upstream address |
| up_pwdata | input | DW | Upstream write data |
| up_pstrb | input | DW/8 | Upstream write strobes |
| up_pprot | input | 3 | Protection: bit1 non-secure, bit0 privileged |
| up_prdata | output | DW | Read data returned upstream |
| up_pready | output | 1 | Transfer completion upstream |
| up_pslverr | output | 1 | Error response upstream |
| dn_psel | output | NPORTS | Per-port downstream select |
| dn_penable | output | 1 | Downstream access phase |
| dn_pwrite | output | 1 | Downstream write flag |
| dn_paddr | output | AW | Downstream address |
| dn_pwdata | output | DW | Downstream write data |
| dn_pstrb | output | DW/8 | Downstream write strobes |
| dn_pprot | output | 3 | Downstream protection |
| dn_prdata | input | NPORTS*DW | Read data of all ports, port j at bits j*DW |
| dn_pready | input | NPORTS | Per-port ready |
| dn_pslverr | input | NPORTS | Per-port error |
| cfg_ns_ok | input | NPORTS | Per-port non-secure permission |
| cfg_user_ok | input | NPORTS | Per-port unprivileged permission |
| cfg_fault_mode | input | 1 | 1: refused transfers error; 0: read zero, drop write |
| irq_en | input | 1 | Interrupt output enable |
| irq_clr | input | 1 | Pending flag clear |
| irq | output | 1 | Rejection interrupt |

## Verification
The hardest case to reach from the ports is a clear that coincides with a rejection. `irq_clr` has to be high on exactly the edge where a refused access phase completes. The bench holds the clear wire high across a whole refused transfer, so that edge is always covered, and then checks that `irq` stays low. A second hard case is a pending flag that was latched while the interrupt was masked. The bench refuses a transfer with `irq_en` low, confirms that `irq` is quiet, and then raises the enable with no new transfer to show the stored flag.

The stimulus table sets each port's permission wires to the opposite value on every other port. A wrong port index in the verdict logic therefore flips the outcome.

// File: rtl/apb_gate_pkg.sv
package apb_gate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_BLOCK = 2'd2
    } gate_state_e;
endpackage

// File: rtl/gate_verdict.sv
// Per-port permission check, reduced to one verdict for the selected port.
module gate_verdict #(
    parameter int                NPORTS     = 16,
    parameter logic [NPORTS-1:0] SEC_BYPASS = '0
) (
    input  logic [NPORTS-1:0] sel,
    input  logic [2:0]        prot,
    input  logic [NPORTS-1:0] ns_ok,
    input  logic [NPORTS-1:0] user_ok,
    output logic              any_sel,
    output logic              allow
);
    localparam int PROT_NS_BIT   = 1;
    localparam int PROT_PRIV_BIT = 0;

    logic              is_ns;
    logic              is_priv;
    logic [NPORTS-1:0] port_ok;

    assign is_ns   = prot[PROT_NS_BIT];
    assign is_priv = prot[PROT_PRIV_BIT];

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        if (SEC_BYPASS[g]) begin : g_bypass
            assign port_ok[g] = is_priv || user_ok[g];
        end else begin : g_checked
            assign port_ok[g] = (!is_ns || ns_ok[g]) && (is_priv || user_ok[g]);
        end
    end

    assign any_sel = |sel;
    assign allow   = |(sel & port_ok);
endmodule

// File: rtl/gate_fsm.sv
// Transfer sequencing: one process for the state register, one for outputs.
module gate_fsm
    import apb_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        any_sel,
    input  logic        penable,
    input  logic        allow,
    input  logic        port_ready,
    output gate_state_e st,
    output logic        fwd_sel,
    output logic        fwd_en,
    output logic        local_done,
    output logic        reject_done
);
    gate_state_e st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (any_sel && !penable) st_nx = allow ? ST_PASS : ST_BLOCK;
            end
            ST_PASS: begin
                if (!any_sel)                     st_nx = ST_IDLE;
                else if (penable && port_ready)   st_nx = ST_IDLE;
            end
            ST_BLOCK: begin
                if (!any_sel || penable) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        fwd_sel     = 1'b0;
        fwd_en      = 1'b0;
        local_done  = 1'b0;
        reject_done = 1'b0;
        unique case (st)
            ST_IDLE: begin
                fwd_sel = any_sel && !penable && allow;
            end
            ST_PASS: begin
                fwd_sel = any_sel;
                fwd_en  = any_sel && penable;
            end
            ST_BLOCK: begin
                local_done  = 1'b1;
                reject_done = any_sel && penable;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/gate_rsp.sv
// Response path: selected port's response, or a locally built one.
module gate_rsp #(
    parameter int NPORTS = 16,
    parameter int DW     = 32
) (
    input  logic [NPORTS-1:0]    sel,
    input  logic [NPORTS*DW-1:0] port_rdata,
    input  logic [NPORTS-1:0]    port_ready,
    input  logic [NPORTS-1:0]    port_err,
    input  logic                 fwd_en,
    input  logic                 local_done,
    input  logic                 fault_mode,
    output logic                 sel_ready,
    output logic [DW-1:0]        rdata,
    output logic                 ready,
    output logic                 err
);
    logic [DW-1:0] masked [NPORTS];
    logic [DW-1:0] muxed;

    for (genvar g = 0; g < NPORTS; g++) begin : g_mask
        assign masked[g] = sel[g] ? port_rdata[g*DW +: DW] : '0;
    end

    always_comb begin
        muxed = '0;
        for (int i = 0; i < NPORTS; i++) muxed = muxed | masked[i];
    end

    assign sel_ready = |(sel & port_ready);

    always_comb begin
        rdata = '0;
        ready = 1'b0;
        err   = 1'b0;
        if (fwd_en) begin
            rdata = muxed;
            ready = sel_ready;
            err   = |(sel & port_err);
        end else if (local_done) begin
            ready = 1'b1;
            err   = fault_mode;
        end
    end
endmodule

// File: rtl/gate_irq.sv
// Latched rejection flag; clear has priority over set.
module gate_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic irq
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pend_q <= 1'b0;
        else if (clr) pend_q <= 1'b0;
        else if (set) pend_q <= 1'b1;
    end

    assign irq = pend_q && en;
endmodule

// File: rtl/apb_access_gate.sv
module apb_access_gate
    import apb_gate_pkg::*;
#(
    parameter int                NPORTS     = 16,
    parameter int                AW         = 32,
    parameter int                DW         = 32,
    parameter logic [NPORTS-1:0] SEC_BYPASS = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORTS-1:0]    up_psel,
    input  logic                 up_penable,
    input  logic                 up_pwrite,
    input  logic [AW-1:0]        up_paddr,
    input  logic [DW-1:0]        up_pwdata,
    input  logic [DW/8-1:0]      up_pstrb,
    input  logic [2:0]           up_pprot,
    output logic [DW-1:0]        up_prdata,
    output logic                 up_pready,
    output logic                 up_pslverr,
    output logic [NPORTS-1:0]    dn_psel,
    output logic                 dn_penable,
    output logic                 dn_pwrite,
    output logic [AW-1:0]        dn_paddr,
    output logic [DW-1:0]        dn_pwdata,
    output logic [DW/8-1:0]      dn_pstrb,
    output logic [2:0]           dn_pprot,
    input  logic [NPORTS*DW-1:0] dn_prdata,
    input  logic [NPORTS-1:0]    dn_pready,
    input  logic [NPORTS-1:0]    dn_pslverr,
    input  logic [NPORTS-1:0]    cfg_ns_ok,
    input  logic [NPORTS-1:0]    cfg_user_ok,
    input  logic                 cfg_fault_mode,
    input  logic                 irq_en,
    input  logic                 irq_clr,
    output logic                 irq
);
    gate_state_e st;
    logic        any_sel;
    logic        allow;
    logic        sel_ready;
    logic        fwd_sel;
    logic        fwd_en;
    logic        local_done;
    logic        reject_done;

    gate_verdict #(.NPORTS(NPORTS), .SEC_BYPASS(SEC_BYPASS)) verdict_i (
        .sel     (up_psel),
        .prot    (up_pprot),
        .ns_ok   (cfg_ns_ok),
        .user_ok (cfg_user_ok),
        .any_sel (any_sel),
        .allow   (allow)
    );

    gate_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_sel     (any_sel),
        .penable     (up_penable),
        .allow       (allow),
        .port_ready  (sel_ready),
        .st          (st),
        .fwd_sel     (fwd_sel),
        .fwd_en      (fwd_en),
        .local_done  (local_done),
        .reject_done (reject_done)
    );

    gate_rsp #(.NPORTS(NPORTS), .DW(DW)) rsp_i (
        .sel        (up_psel),
        .port_rdata (dn_prdata),
        .port_ready (dn_pready),
        .port_err   (dn_pslverr),
        .fwd_en     (fwd_en),
        .local_done (local_done),
        .fault_mode (cfg_fault_mode),
        .sel_ready  (sel_ready),
        .rdata      (up_prdata),
        .ready      (up_pready),
        .err        (up_pslverr)
    );

    gate_irq irq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (reject_done),
        .clr   (irq_clr),
        .en    (irq_en),
        .irq   (irq)
    );

    assign dn_psel    = fwd_sel ? up_psel : '0;
    assign dn_penable = fwd_en;
    assign dn_pwrite  = up_pwrite;
    assign dn_paddr   = up_paddr;
    assign dn_pwdata  = up_pwdata;
    assign dn_pstrb   = up_pstrb;
    assign dn_pprot   = up_pprot;
endmodule

// File: rtl/apb_access_gate_chk.sv
module apb_access_gate_chk
    import apb_gate_pkg::*;
#(
    parameter int NPORTS = 16,
    parameter int DW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input gate_state_e       st,
    input logic              up_penable,
    input logic [DW-1:0]     up_prdata,
    input logic              up_pready,
    input logic              up_pslverr,
    input logic [NPORTS-1:0] dn_psel,
    input logic              dn_penable,
    input logic              cfg_fault_mode,
    input logic              irq_en,
    input logic              irq_clr,
    input logic              irq
);
    AST_BLOCK_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BLOCK) |-> (dn_psel == '0 && !dn_penable)); // R5
    AST_BLOCK_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BLOCK && up_penable) |-> up_pready); // R5
    AST_BLOCK_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BLOCK && cfg_fault_mode) |-> (up_pslverr && up_prdata == '0)); // R6
    AST_BLOCK_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BLOCK && !cfg_fault_mode) |-> (!up_pslverr && up_prdata == '0)); // R7
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BLOCK && up_penable && !irq_clr && irq_en) |=> (irq || !irq_en)); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R8
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> !irq); // R9
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_psel)); // R1
    AST_IDLE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !dn_penable); // R11
endmodule

bind apb_access_gate apb_access_gate_chk #(.NPORTS(NPORTS), .DW(DW)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .st             (st),
    .up_penable     (up_penable),
    .up_prdata      (up_prdata),
    .up_pready      (up_pready),
    .up_pslverr     (up_pslverr),
    .dn_psel        (dn_psel),
    .dn_penable     (dn_penable),
    .cfg_fault_mode (cfg_fault_mode),
    .irq_en         (irq_en),
    .irq_clr        (irq_clr),
    .irq            (irq)
);

// File: tb/apb_access_gate_tb_top.sv
module apb_access_gate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 16;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam logic [NP-1:0] BYPASS = 16'h8000;
    localparam int NVEC = 10;
    // {port[10:7], ns[6], priv[5], ns_ok[4], user_ok[3], fault[2], write[1], allowed[0]}
    localparam logic [10:0] VEC [NVEC] = '{
        {4'd3,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // secure privileged: R1
        {4'd5,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // ns refused, fault: R2 R6
        {4'd5,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // ns permitted write: R2
        {4'd7,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // user refused, raz: R3 R7
        {4'd7,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},  // user permitted: R3
        {4'd15, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // bypass port: R4
        {4'd15, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // bypass, user refused: R4
        {4'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // both permitted: R2 R3
        {4'd9,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // refused write raz: R7
        {4'd12, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}   // secure user permitted: R3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] up_psel = '0;
    logic up_penable = 1'b0, up_pwrite = 1'b0;
    logic [AW-1:0] up_paddr = '0;
    logic [DW-1:0] up_pwdata = '0;
    logic [DW/8-1:0] up_pstrb = '0;
    logic [2:0] up_pprot = '0;
    logic [DW-1:0] up_prdata;
    logic up_pready, up_pslverr;
    logic [NP-1:0] dn_psel;
    logic dn_penable, dn_pwrite;
    logic [AW-1:0] dn_paddr;
    logic [DW-1:0] dn_pwdata;
    logic [DW/8-1:0] dn_pstrb;
    logic [2:0] dn_pprot;
    logic [NP*DW-1:0] dn_prdata;
    logic [NP-1:0] dn_pready = '1;
    logic [NP-1:0] dn_pslverr = '0;
    logic [NP-1:0] cfg_ns_ok = '0, cfg_user_ok = '0;
    logic cfg_fault_mode = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
    logic irq;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    logic [NP-1:0] s_setup_sel, s_sel;
    logic s_en, s_ready, s_err;
    logic [DW-1:0] s_rdata, s_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar g = 0; g < NP; g++) begin : g_model
        assign dn_prdata[g*DW +: DW] = 32'hC0DE_0000 + g;
    end

    apb_access_gate #(.NPORTS(NP), .AW(AW), .DW(DW), .SEC_BYPASS(BYPASS)) dut_i (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input int p, input logic ns, input logic priv, input logic wr, input logic [DW-1:0] wd);
        @(negedge clk);
        up_psel = NP'(1) << p;
        up_penable = 1'b0;
        up_pwrite = wr;
        up_paddr = 32'h4000_0000 + 32'(p) * 32'h100;
        up_pwdata = wd;
        up_pstrb = '1;
        up_pprot = {1'b0, ns, priv};
        #1 s_setup_sel = dn_psel;
        @(negedge clk);
        up_penable = 1'b1;
        #1;
        s_sel = dn_psel; s_en = dn_penable; s_ready = up_pready;
        s_err = up_pslverr; s_rdata = up_prdata; s_wdata = dn_pwdata;
        while (!up_pready) @(negedge clk);
        @(negedge clk);
        up_psel = '0;
        up_penable = 1'b0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R10", "dn_psel in reset", 32'(dn_psel), 32'h0);
        chk("R10", "irq in reset", 32'(irq), 32'h0);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R10", "pready after reset", 32'(up_pready), 32'h0);
        irq_en = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            int p;
            logic [NP-1:0] onehot;
            logic allowed;
            p = int'(VEC[i][10:7]);
            onehot = NP'(1) << p;
            allowed = VEC[i][0];
            cfg_ns_ok = VEC[i][4] ? onehot : ~onehot;
            cfg_user_ok = VEC[i][3] ? onehot : ~onehot;
            cfg_fault_mode = VEC[i][2];
            xfer(p, VEC[i][6], VEC[i][5], VEC[i][1], 32'hA5A5_0000 + 32'(i));
            if (allowed) begin
                chk("R1", "setup dn_psel", 32'(s_setup_sel), 32'(onehot));
                chk("R1", "access dn_psel", 32'(s_sel), 32'(onehot));
                chk("R1", "dn_penable", 32'(s_en), 32'h1);
                chk("R1", "rdata", s_rdata, 32'hC0DE_0000 + 32'(p));
                chk("R1", "wdata pass", s_wdata, 32'hA5A5_0000 + 32'(i));
                chk("R1", "err", 32'(s_err), 32'h0);
                chk("R8", "irq stays low", 32'(irq), 32'h0);
            end else begin
                chk("R5", "setup dn_psel", 32'(s_setup_sel), 32'h0);
                chk("R5", "access dn_psel", 32'(s_sel), 32'h0);
                chk("R5", "dn_penable", 32'(s_en), 32'h0);
                chk("R5", "pready", 32'(s_ready), 32'h1);
                chk(VEC[i][2] ? "R6" : "R7", "rdata zero", s_rdata, 32'h0);
                chk(VEC[i][2] ? "R6" : "R7", "err", 32'(s_err), 32'(VEC[i][2]));
                chk("R8", "irq raised", 32'(irq), 32'h1);
            end
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            #1;
            chk("R9", "irq cleared", 32'(irq), 32'h0);
        end

        // R11: wait states keep the transfer forwarded
        cfg_ns_ok = '1; cfg_user_ok = '1; dn_pready[3] = 1'b0;
        @(negedge clk);
        up_psel = NP'(1) << 3; up_pprot = 3'b001; up_pwrite = 1'b0;
        @(negedge clk);
        up_penable = 1'b1;
        #1;
        chk("R11", "pready held low", 32'(up_pready), 32'h0);
        @(negedge clk);
        #1;
        chk("R11", "still forwarding", 32'(dn_psel), 32'h8);
        chk("R11", "still enabled", 32'(dn_penable), 32'h1);
        dn_pready[3] = 1'b1;
        #1;
        chk("R11", "pready released", 32'(up_pready), 32'h1);
        @(negedge clk);
        up_psel = '0; up_penable = 1'b0;
        #1;
        chk("R11", "back to idle", 32'(dn_psel), 32'h0);

        // R1: port error passes upstream
        dn_pslverr[6] = 1'b1;
        xfer(6, 1'b0, 1'b1, 1'b0, 32'h0);
        chk("R1", "port error returned", 32'(s_err), 32'h1);
        dn_pslverr[6] = 1'b0;

        // R8: rejection latched while masked
        irq_en = 1'b0; cfg_user_ok = '0; cfg_fault_mode = 1'b0;
        xfer(2, 1'b0, 1'b0, 1'b1, 32'h0);
        chk("R8", "masked irq low", 32'(irq), 32'h0);
        irq_en = 1'b1;
        #1;
        chk("R8", "stored flag shown", 32'(irq), 32'h1);
        irq_clr = 1'b1;
        @(negedge clk);
        // R9: clear held during a rejection wins
        xfer(4, 1'b0, 1'b0, 1'b0, 32'h0);
        chk("R9", "clear beats rejection", 32'(irq), 32'h0);
        irq_clr = 1'b0;
        @(negedge clk);
        #1;
        chk("R9", "flag stays clear", 32'(irq), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end
endmodule